// File: doc/BRIEF.md
# Four-wire display command host (8-bit words, separate data/command line)

This block is an SPI master for small display controllers that take 8-bit words and mark each word as command or data on a dedicated select line. A client presents one request at a time: a command byte, a length, a read flag and a runtime clock divider. For writes, the block sends the command byte and then pulls parameter bytes one by one from a streaming input. For reads, it sends the command byte and then clocks in the requested bytes without releasing chip select. Read bytes come back on a small valid/data output.

The serial clock half-period comes from the runtime divider, but it is capped per transfer kind. Control traffic is limited to a 10 MHz ceiling. Long parameter bursts run at the full configured rate. Reads are held to the slower of a 2 MHz ceiling and half the configured rate. Both ceilings are turned into minimum half-periods from the system clock frequency parameter. The identity and status reads are answered by some controllers after one dummy clock. The block takes one extra byte for them and shifts the stream back into alignment. Each request ends with a done pulse that carries an error bit.

Top module: `dsh_spi_host`

## Requirements
- R1: On a write, `dc` is 0 while the command byte is shifted and 1 while every parameter byte is shifted; parameter bytes go out in the order supplied on `par_data`, one per `par_take` pulse.
- R2: The SCLK half-period, in system clocks, is the divider value (0 counts as 1). For the command byte of a write, and for a payload of at most 64 bytes, it is raised to at least ceil(CLK_HZ/20 MHz), 7 at 125 MHz. For a payload of more than 64 bytes, the divider is used unchanged.
- R3: For a read, every byte (the command byte and the returned bytes) uses a half-period of max(2*divider, ceil(CLK_HZ/4 MHz)), which is 32 at 125 MHz.
- R4: For a read, `dc` stays 0 for the whole transaction and chip select falls once. The command byte is followed by exactly the requested number of bytes, sent as 0x00, and each received byte is presented on `rd_data` with a one-cycle `rd_valid`.
- R5: Reads of command 0x04 or 0x09 accept only lengths 3 and 4; any other length ends with an error and no bus activity. For an accepted length N, N+1 bytes are clocked in, and result byte i is received byte i shifted left by one, with bit 7 of received byte i+1 as its bit 0.
- R6: A read with length 0 is rejected with `err` and no bus activity.
- R7: SPI mode 0, MSB first: SCLK idles low and stays low while chip select is high, and MOSI changes only while SCLK is low.
- R8: Every request ends with one `done` pulse, raised with `cs_n` already high. `err` is 1 only with `done`. A request presented while `busy` is 1 is ignored.
- R9: A write with length 0 sends only the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_cmd | input | 8 | Command byte |
| req_read | input | 1 | 1 = read request, 0 = write request |
| req_len | input | LEN_W | Payload length for writes, byte count for reads |
| rate_div | input | DIV_W | SCLK half-period at the fastest allowed rate, in system clocks |
| par_data | input | 8 | Current parameter byte |
| par_take | output | 1 | Pulse: `par_data` consumed, present the next byte |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | Pulse qualifying `rd_data` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Pulse at end of request |
| err | output | 1 | Request rejected, valid with `done` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | 0 = command word, 1 = data word |

## Verification
Writes are driven with a short payload and a slow divider, which exposes the control-rate floor and the command/data switch. They are also driven with a payload just past the 64-byte threshold, which shows the command byte slow and the burst fast. Reads are run at a divider below and above the read floor, so the cap and the doubling rule give different periods. The identity and status reads use responses whose bit patterns differ between realigned and plain capture. Rejected lengths, a zero-length write and a request arriving while busy show, from the bus and the done/error outputs, whether the block kept quiet or did only the expected work.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
   typedef enum logic [1:0] {RATE_CTRL, RATE_BULK, RATE_READ} rate_kind_t;
   typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_PAR, ST_RDB, ST_FIN} host_st_t;
   localparam logic [7:0] OP_GET_IDENT  = 8'h04;
   localparam logic [7:0] OP_GET_STATUS = 8'h09;
endpackage

// File: rtl/dsh_rate_pick.sv
module dsh_rate_pick import dsh_pkg::*; #(
   parameter int DIV_W    = 8,
   parameter int CTRL_MIN = 7,
   parameter int READ_MIN = 32
) (
   input  logic [DIV_W-1:0] rate_div,
   input  rate_kind_t       kind,
   output logic [DIV_W:0]   half_per
);
   localparam int EW = DIV_W + 1;

   logic [EW-1:0] base, dbl, ctrl_v, read_v;

   if (CTRL_MIN >= 2**EW || READ_MIN >= 2**EW) begin : g_range
      $error("divider width too small for the rate floors");
   end

   assign base = (rate_div == '0) ? EW'(1) : {1'b0, rate_div};
   assign dbl  = base << 1;

   if (CTRL_MIN > 1) begin : g_ctrl_cap
      assign ctrl_v = (base < EW'(CTRL_MIN)) ? EW'(CTRL_MIN) : base;
   end else begin : g_ctrl_free
      assign ctrl_v = base;
   end

   if (READ_MIN > 1) begin : g_read_cap
      assign read_v = (dbl < EW'(READ_MIN)) ? EW'(READ_MIN) : dbl;
   end else begin : g_read_free
      assign read_v = dbl;
   end

   always_comb begin
      unique case (kind)
         RATE_BULK: half_per = base;
         RATE_READ: half_per = read_v;
         default:   half_per = ctrl_v;
      endcase
   end
endmodule

// File: rtl/dsh_byte_shift.sv
module dsh_byte_shift #(
   parameter int HW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [HW-1:0] half,
   input  logic [7:0]    tx,
   input  logic          miso,
   output logic          sclk,
   output logic          mosi,
   output logic          busy,
   output logic          done,
   output logic [7:0]    rx
);
   logic [HW-1:0] cnt, half_q;
   logic [2:0]    bitn;
   logic [7:0]    sh;

   assign mosi = sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; half_q <= '0; bitn <= '0; sh <= '0; rx <= '0;
         sclk <= 1'b0; busy <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            sh     <= tx;
            half_q <= half;
            cnt    <= half - HW'(1);
            bitn   <= '0;
            sclk   <= 1'b0;
         end else if (busy) begin
            if (cnt != '0) begin
               cnt <= cnt - HW'(1);
            end else begin
               cnt <= half_q - HW'(1);
               if (!sclk) begin
                  sclk <= 1'b1;
                  rx   <= {rx[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bitn == 3'd7) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bitn <= bitn + 3'd1;
                     sh   <= {sh[6:0], 1'b0};
                  end
               end
            end
         end
      end
   end

   assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
   assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/dsh_rx_align.sv
module dsh_rx_align (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       shift_en,
   input  logic [7:0] byte_in,
   input  logic       byte_vld,
   output logic [7:0] out,
   output logic       out_vld
);
   logic       have;
   logic [7:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have <= 1'b0; prev <= '0; out <= '0; out_vld <= 1'b0;
      end else begin
         out_vld <= 1'b0;
         if (clear) begin
            have <= 1'b0;
         end else if (byte_vld) begin
            prev <= byte_in;
            if (!shift_en) begin
               out     <= byte_in;
               out_vld <= 1'b1;
            end else if (!have) begin
               have <= 1'b1;
            end else begin
               out     <= {prev[6:0], byte_in[7]};
               out_vld <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsh_spi_host.sv
module dsh_spi_host import dsh_pkg::*; #(
   parameter int CLK_HZ   = 125_000_000,
   parameter int CTRL_HZ  = 10_000_000,
   parameter int READ_HZ  = 2_000_000,
   parameter int DIV_W    = 8,
   parameter int LEN_W    = 8,
   parameter int BULK_MAX = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [7:0]       req_cmd,
   input  logic             req_read,
   input  logic [LEN_W-1:0] req_len,
   input  logic [DIV_W-1:0] rate_div,
   input  logic [7:0]       par_data,
   output logic             par_take,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso,
   output logic             cs_n,
   output logic             dc
);
   localparam int CW       = LEN_W + 1;
   localparam int HW       = DIV_W + 1;
   localparam int CTRL_MIN = (CLK_HZ + 2*CTRL_HZ - 1) / (2*CTRL_HZ);
   localparam int READ_MIN = (CLK_HZ + 2*READ_HZ - 1) / (2*READ_HZ);

   if (LEN_W < 3 || BULK_MAX >= 2**LEN_W) begin : g_len_chk
      $error("LEN_W must hold length 4 and the bulk threshold");
   end

   host_st_t   st;
   logic [CW-1:0] cnt;
   logic       rd_q, align_q, bulk_q;
   logic       eng_start, eng_busy, eng_done, al_clear, is_idop, bad;
   logic [7:0] eng_tx, eng_rx;
   rate_kind_t kind;
   logic [HW-1:0] half;

   assign is_idop = (req_cmd == OP_GET_IDENT) || (req_cmd == OP_GET_STATUS);
   assign bad = req_read && ((req_len == '0) ||
                (is_idop && req_len != LEN_W'(3) && req_len != LEN_W'(4)));
   assign busy = (st != ST_IDLE);

   always_comb begin
      eng_start = 1'b0;
      eng_tx    = 8'h00;
      par_take  = 1'b0;
      kind      = RATE_CTRL;
      al_clear  = 1'b0;
      unique case (st)
         ST_IDLE: if (req_valid && !bad) begin
            eng_start = 1'b1;
            eng_tx    = req_cmd;
            kind      = req_read ? RATE_READ : RATE_CTRL;
         end
         ST_CMD: if (eng_done) begin
            if (rd_q) begin
               eng_start = 1'b1;
               kind      = RATE_READ;
               al_clear  = 1'b1;
            end else if (cnt != '0) begin
               eng_start = 1'b1;
               eng_tx    = par_data;
               par_take  = 1'b1;
               kind      = bulk_q ? RATE_BULK : RATE_CTRL;
            end
         end
         ST_PAR: if (eng_done && cnt != CW'(1)) begin
            eng_start = 1'b1;
            eng_tx    = par_data;
            par_take  = 1'b1;
            kind      = bulk_q ? RATE_BULK : RATE_CTRL;
         end
         ST_RDB: if (eng_done && cnt != CW'(1)) begin
            eng_start = 1'b1;
            kind      = RATE_READ;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cnt <= '0; rd_q <= 1'b0; align_q <= 1'b0; bulk_q <= 1'b0;
         cs_n <= 1'b1; dc <= 1'b0; done <= 1'b0; err <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               if (bad) begin
                  done <= 1'b1;
                  err  <= 1'b1;
               end else begin
                  st      <= ST_CMD;
                  cs_n    <= 1'b0;
                  dc      <= 1'b0;
                  rd_q    <= req_read;
                  align_q <= req_read && is_idop;
                  bulk_q  <= req_len > LEN_W'(BULK_MAX);
                  cnt     <= (req_read && is_idop) ? CW'(req_len) + CW'(1) : CW'(req_len);
               end
            end
            ST_CMD: if (eng_done) begin
               if (rd_q) st <= ST_RDB;
               else if (cnt != '0) begin
                  st <= ST_PAR;
                  dc <= 1'b1;
               end else st <= ST_FIN;
            end
            ST_PAR, ST_RDB: if (eng_done) begin
               if (cnt == CW'(1)) st <= ST_FIN;
               else cnt <= cnt - CW'(1);
            end
            ST_FIN: begin
               cs_n <= 1'b1;
               dc   <= 1'b0;
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   dsh_rate_pick #(.DIV_W(DIV_W), .CTRL_MIN(CTRL_MIN), .READ_MIN(READ_MIN)) u_rate (
      .rate_div(rate_div), .kind(kind), .half_per(half));

   dsh_byte_shift #(.HW(HW)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .half(half), .tx(eng_tx),
      .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done),
      .rx(eng_rx));

   dsh_rx_align u_align (
      .clk(clk), .rst_n(rst_n), .clear(al_clear), .shift_en(align_q),
      .byte_in(eng_rx), .byte_vld(eng_done && st == ST_RDB),
      .out(rd_data), .out_vld(rd_valid));

   assert_dc_low_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDB) |-> !dc);
   assert_sclk_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   assert_rd_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cs_n);
   assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);
   assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (cs_n && $past(cs_n)));
   assert_busy_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> busy);
endmodule

// File: tb/sim_dsh_spi_host.sv
`timescale 1ns/1ps
module sim_dsh_spi_host;
   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_read = 1'b0;
   logic [7:0] req_cmd = '0;
   logic [7:0] req_len = '0;
   logic [7:0] rate_div = 8'd1;
   logic [7:0] par_data, rd_data;
   logic par_take, rd_valid, busy, done, err, sclk, mosi, miso, cs_n, dc;

   always #4 clk = ~clk;

   dsh_spi_host u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_read(req_read), .req_len(req_len), .rate_div(rate_div), .par_data(par_data),
      .par_take(par_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
      .done(done), .err(err), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .dc(dc));

   int nchk = 0, nfail = 0;
   logic [7:0] pbuf [0:127];
   int pidx = 0;
   assign par_data = pbuf[pidx];
   always @(posedge clk) if (done) pidx <= 0; else if (par_take) pidx <= pidx + 1;

   logic [47:0] resp = '0;
   int bitcnt = 0;
   assign miso = (bitcnt < 48) ? resp[47 - bitcnt] : 1'b0;
   always @(negedge sclk or posedge cs_n) if (cs_n !== 1'b0) bitcnt = 0; else bitcnt = bitcnt + 1;

   logic [7:0] blog [0:511];
   logic       bdc  [0:511];
   longint     bper [0:511];
   int nbus = 0, bpos = 0;
   logic [7:0] bsh = '0;
   longint t0 = 0;
   always @(posedge sclk) begin
      bsh = {bsh[6:0], mosi};
      if (bpos == 0) begin t0 = $time; bdc[nbus] = dc; end
      if (bpos == 1) bper[nbus] = $time - t0;
      if (bpos == 7) begin blog[nbus] = bsh; nbus = nbus + 1; end
      bpos = (bpos + 1) % 8;
   end

   int ncsf = 0, ndone = 0, nrd = 0;
   logic last_err = 1'b0;
   logic [7:0] rdlog [0:63];
   always @(negedge cs_n) ncsf = ncsf + 1;
   always @(posedge clk) begin
      if (done) begin ndone <= ndone + 1; last_err <= err; end
      if (rd_valid) begin rdlog[nrd] <= rd_data; nrd <= nrd + 1; end
   end

   int b0, c0, d0, r0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic pulse_req(input [7:0] c, input int n, input bit rd, input int dv);
      @(negedge clk);
      req_cmd = c; req_len = 8'(n); req_read = rd; rate_div = 8'(dv); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic issue(input [7:0] c, input int n, input bit rd, input int dv);
      b0 = nbus; c0 = ncsf; d0 = ndone; r0 = nrd;
      pulse_req(c, n, rd, dv);
      wait (ndone == d0 + 1);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(cs_n == 1'b1 && sclk == 1'b0 && dc == 1'b0, "R7 idle pins", {cs_n, sclk, dc}, 3'b100);
      chk(busy == 1'b0 && done == 1'b0, "R8 reset state", {busy, done}, 0);
   endtask

   task automatic t_write_short;
      for (int i = 0; i < 4; i++) pbuf[i] = 8'(8'h31 + 17 * i);
      issue(8'h2A, 4, 1'b0, 2);
      chk(nbus - b0 == 5, "R1 byte count", nbus - b0, 5);
      chk(blog[b0] == 8'h2A && bdc[b0] == 1'b0, "R1 command byte", {bdc[b0], blog[b0]}, 8'h2A);
      for (int i = 0; i < 4; i++) begin
         chk(blog[b0+1+i] == pbuf[i] && bdc[b0+1+i] == 1'b1, "R1 parameter byte",
             {bdc[b0+1+i], blog[b0+1+i]}, {1'b1, pbuf[i]});
         chk(bper[b0+1+i] == 112, "R2 short payload period", bper[b0+1+i], 112);
      end
      chk(bper[b0] == 112, "R2 command period", bper[b0], 112);
      chk(last_err == 1'b0, "R8 no error", last_err, 0);
   endtask

   task automatic t_write_bulk;
      int bad = 0;
      for (int i = 0; i < 65; i++) pbuf[i] = 8'(i * 37 + 5);
      issue(8'h2C, 65, 1'b0, 2);
      chk(nbus - b0 == 66, "R2 bulk count", nbus - b0, 66);
      chk(bper[b0] == 112, "R2 bulk command period", bper[b0], 112);
      for (int i = 0; i < 65; i++)
         if (blog[b0+1+i] != pbuf[i] || bper[b0+1+i] != 32 || bdc[b0+1+i] != 1'b1) bad++;
      chk(bad == 0, "R2 bulk bytes at full rate", bad, 0);
   endtask

   task automatic t_write_slow;
      pbuf[0] = 8'h81; pbuf[1] = 8'h7E;
      issue(8'h36, 2, 1'b0, 10);
      chk(bper[b0] == 160 && bper[b0+2] == 160, "R2 divider above floor", bper[b0+2], 160);
      chk(blog[b0+2] == 8'h7E, "R7 msb first", blog[b0+2], 8'h7E);
   endtask

   task automatic t_write_nopar;
      issue(8'h29, 0, 1'b0, 3);
      chk(nbus - b0 == 1 && blog[b0] == 8'h29, "R9 command only", nbus - b0, 1);
   endtask

   task automatic t_read_plain;
      resp = {8'h00, 8'hA5, 8'h3C, 24'h0};
      issue(8'h0A, 2, 1'b1, 3);
      chk(nbus - b0 == 3, "R4 bytes clocked", nbus - b0, 3);
      chk(ncsf - c0 == 1, "R4 single chip select", ncsf - c0, 1);
      chk(bdc[b0] == 0 && bdc[b0+1] == 0 && bdc[b0+2] == 0, "R4 dc low", bdc[b0+1], 0);
      chk(blog[b0] == 8'h0A && blog[b0+1] == 8'h00, "R4 command then zeros", blog[b0+1], 0);
      chk(bper[b0] == 512 && bper[b0+2] == 512, "R3 read floor period", bper[b0+2], 512);
      chk(nrd - r0 == 2 && rdlog[r0] == 8'hA5 && rdlog[r0+1] == 8'h3C, "R4 read data",
          {rdlog[r0], rdlog[r0+1]}, 16'hA53C);
   endtask

   task automatic t_read_half;
      resp = {8'h00, 8'h5A, 32'h0};
      issue(8'h0B, 1, 1'b1, 20);
      chk(bper[b0] == 640 && bper[b0+1] == 640, "R3 half configured rate", bper[b0], 640);
      chk(rdlog[r0] == 8'h5A, "R4 single read byte", rdlog[r0], 8'h5A);
   endtask

   task automatic t_read_align(input [7:0] c, input int n);
      logic [7:0] r [0:4];
      int bad = 0;
      r[0] = 8'hC3; r[1] = 8'h96; r[2] = 8'h2D; r[3] = 8'hF0; r[4] = 8'hB5;
      resp = {8'h00, r[0], r[1], r[2], r[3], r[4]};
      issue(c, n, 1'b1, 3);
      chk(nbus - b0 == n + 2, "R5 extra byte clocked", nbus - b0, n + 2);
      chk(nrd - r0 == n, "R5 result count", nrd - r0, n);
      for (int i = 0; i < n; i++)
         if (rdlog[r0+i] != {r[i][6:0], r[i+1][7]}) bad++;
      chk(bad == 0, "R5 realigned bytes", rdlog[r0], {r[0][6:0], r[1][7]});
   endtask

   task automatic t_reject(input [7:0] c, input int n, input string tag);
      issue(c, n, 1'b1, 3);
      chk(last_err == 1'b1, tag, last_err, 1);
      chk(nbus == b0 && ncsf == c0 && nrd == r0, tag, nbus - b0, 0);
   endtask

   task automatic t_busy_ignore;
      for (int i = 0; i < 4; i++) pbuf[i] = 8'(8'hE0 + i);
      b0 = nbus; c0 = ncsf; d0 = ndone;
      pulse_req(8'h2C, 4, 1'b0, 2);
      repeat (100) @(negedge clk);
      pulse_req(8'h55, 0, 1'b0, 2);
      wait (ndone == d0 + 1);
      repeat (300) @(negedge clk);
      chk(ndone - d0 == 1 && ncsf - c0 == 1, "R8 busy request ignored", ndone - d0, 1);
      chk(nbus - b0 == 5 && blog[b0] == 8'h2C, "R8 first request intact", nbus - b0, 5);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) pbuf[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_write_short();
      t_write_bulk();
      t_write_slow();
      t_write_nopar();
      t_read_plain();
      t_read_half();
      t_read_align(8'h04, 3);
      t_read_align(8'h09, 4);
      t_reject(8'h04, 2, "R5 bad identity length");
      t_reject(8'h09, 5, "R5 bad status length");
      t_reject(8'h0A, 0, "R6 zero length read");
      t_busy_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(150000 * 8);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule